// File: doc/BRIEF.md
# Serial Binary Image Frame Capture

This block collects a 14x14 black/white picture that arrives seven pixels at a time on a narrow parallel bus. It assembles the picture into one flat 196-bit frame for a classifier downstream. Two consecutive bus cycles make up one image row: the first carries the left half, the second carries the right half. A full picture therefore takes 28 cycles. The top bus bit is an active-low start strobe and carries no pixel data.

The block finds a start at the high-to-low transition of the strobe bit. The pixels present in that same cycle are stored as the first chunk. Each following cycle is taken as the next chunk until all 28 are stored. A new start part-way through a picture discards the partial picture and begins again. Once the last chunk is stored, `frame_valid` pulses for one cycle and the frame stays frozen until the next start.

The input side has no valid/ready handshake: the sender pushes one chunk every cycle. The output side has no back-pressure either. `frame_valid` is a one-cycle notice, and the consumer may read `frame_bits` at any time until the next start strobe.

Top module: `bitmap_frame_rx`

## Requirements
- R1: A synchronous active-high `rst` clears `frame_bits` to all zeros, drops `frame_valid` and puts the block in idle.
- R2: A start is a cycle in which `in_bus[7]` is low after being high in the previous cycle. The first low cycle after reset also counts as a start. Bits 6..0 of the start cycle are stored as chunk 0.
- R3: Chunk k (0..27), bus bit j (0..6), is stored as the pixel at row k/2, column (k mod 2)*7 + j. That pixel is `frame_bits[row*14 + column]`, so bus bit 0 is the leftmost pixel of its half-row.
- R4: `frame_valid` is high for exactly one cycle: the cycle right after the one that carried chunk 27. It is never raised for a partial picture.
- R5: From the end of a picture until the next start, `frame_bits` does not change, whatever appears on bits 6..0.
- R6: A start that arrives before chunk 27 abandons the partial picture and restarts at chunk 0. The completed frame then holds only the new picture.
- R7: In the cycle after a start, `frame_bits` holds the start cycle's seven pixels in bits 6..0 and zeros in every other bit.
- R8: While a picture is being captured, `in_bus[7]` held low is not a new start: those cycles are captured as ordinary chunks. After the picture, a strobe held low does not alter the frame.
- R9: A start in the cycle right after chunk 27 begins a new picture with no lost chunk, so pictures can arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bus | input | 8 | Bits 6..0 pixels of one half-row; bit 7 active-low start strobe |
| frame_valid | output | 1 | One-cycle pulse when a full picture is stored |
| frame_bits | output | 196 | Assembled picture, pixel (r,c) at bit r*14+c |

## Verification
The pictures used are an asymmetric line shape, a checkerboard, all ones, random pictures, and pictures with a single pixel lit in a corner. Each one shows a different placement fault: the line shape exposes swapped halves or rows, the checkerboard exposes an off-by-one column, the corner pixels expose an end-of-range slip, and random data catches scattered bit errors. The strobe is also driven in several ways, each aimed at one control path: held low through a whole picture, restarted mid-picture, sent back to back, and left idle with random pixels. These separate the start detection from the chunk counter.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } cap_state_e;
endpackage

// File: rtl/bfr_start_detect.sv
module bfr_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic start
);
  logic prev_n;

  always_ff @(posedge clk) begin
    if (rst) prev_n <= 1'b1;
    else     prev_n <= strobe_n;
  end

  assign start = prev_n & ~strobe_n;
endmodule

// File: rtl/bfr_chunk_seq.sv
module bfr_chunk_seq #(
  parameter int NCHUNK = 28,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             clear,
  output logic             done,
  output logic             busy
);
  import bfr_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHUNK - 1);

  cap_state_e       state;
  logic [IDX_W-1:0] cnt;

  assign busy   = (state == ST_CAPT);
  assign wr_en  = start | busy;
  assign wr_idx = start ? '0 : cnt;
  assign clear  = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= busy && !start && (cnt == LAST);
      if (start) begin
        state <= ST_CAPT;
        cnt   <= IDX_W'(1);
      end else if (busy) begin
        if (cnt == LAST) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bfr_frame_store.sv
module bfr_frame_store #(
  parameter int NCHUNK  = 28,
  parameter int CHUNK_W = 7,
  parameter int IDX_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        clear,
  input  logic [CHUNK_W-1:0]          pix,
  output logic [NCHUNK*CHUNK_W-1:0]   frame
);
  for (genvar g = 0; g < NCHUNK; g++) begin : g_slot
    logic [CHUNK_W-1:0] slot;
    logic               hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst)        slot <= '0;
      else if (hit)   slot <= pix;
      else if (clear) slot <= '0;
    end

    assign frame[g*CHUNK_W +: CHUNK_W] = slot;
  end
endmodule

// File: rtl/bitmap_frame_rx.sv
module bitmap_frame_rx #(
  parameter int ROWS    = 14,
  parameter int COLS    = 14,
  parameter int CHUNK_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CHUNK_W:0]       in_bus,
  output logic                   frame_valid,
  output logic [ROWS*COLS-1:0]   frame_bits
);
  localparam int HALVES  = COLS / CHUNK_W;
  localparam int NCHUNK  = ROWS * HALVES;
  localparam int FRAME_W = ROWS * COLS;
  localparam int IDX_W   = $clog2(NCHUNK);

  logic             start_w;
  logic             wr_en_w;
  logic [IDX_W-1:0] wr_idx_w;
  logic             clear_w;
  logic             busy_w;

  bfr_start_detect u_start (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (in_bus[CHUNK_W]),
    .start    (start_w)
  );

  bfr_chunk_seq #(.NCHUNK(NCHUNK), .IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start_w),
    .wr_en  (wr_en_w),
    .wr_idx (wr_idx_w),
    .clear  (clear_w),
    .done   (frame_valid),
    .busy   (busy_w)
  );

  bfr_frame_store #(.NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en_w),
    .wr_idx (wr_idx_w),
    .clear  (clear_w),
    .pix    (in_bus[CHUNK_W-1:0]),
    .frame  (frame_bits)
  );
endmodule

// File: rtl/bfr_checker.sv
module bfr_checker #(
  parameter int NCHUNK  = 28,
  parameter int CHUNK_W = 7,
  parameter int FRAME_W = 196,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [CHUNK_W:0]   in_bus,
  input logic               frame_valid,
  input logic [FRAME_W-1:0] frame_bits,
  input logic               start,
  input logic               busy,
  input logic [IDX_W-1:0]   wr_idx
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (frame_bits == '0) && !frame_valid && !busy);

  assert_start_enters_capture_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_index_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    wr_idx < IDX_W'(NCHUNK));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  assert_valid_ends_capture_R4: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(busy) && !busy);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(frame_bits));

  assert_restart_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> busy && !frame_valid);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> (frame_bits[FRAME_W-1:CHUNK_W] == '0) &&
              (frame_bits[CHUNK_W-1:0] == $past(in_bus[CHUNK_W-1:0])));
endmodule

bind bitmap_frame_rx bfr_checker #(
  .NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_bus      (in_bus),
  .frame_valid (frame_valid),
  .frame_bits  (frame_bits),
  .start       (start_w),
  .busy        (busy_w),
  .wr_idx      (wr_idx_w)
);

// File: tb/bitmap_frame_rx_bench.sv
module bitmap_frame_rx_bench;
  localparam int ROWS = 14, COLS = 14, CW = 7;
  localparam int FW = ROWS * COLS;
  localparam int NCH = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW:0]   in_bus = '1;
  logic          frame_valid;
  logic [FW-1:0] frame_bits;

  logic [FW-1:0] exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit prev_valid = 1'b0;
  bit done_flag  = 1'b0;

  always #5 clk = ~clk;

  bitmap_frame_rx u_bitmap_frame_rx (
    .clk(clk), .rst(rst), .in_bus(in_bus),
    .frame_valid(frame_valid), .frame_bits(frame_bits)
  );

  task automatic check(input bit ok, input string req,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected frames on each valid pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid) begin
        if (prev_valid)
          check(1'b0, "R4 pulse longer than one cycle", FW'(1), FW'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected frame", frame_bits, '0);
        end else begin
          logic [FW-1:0] e;
          e = exp_q.pop_front();
          check(frame_bits == e, "R3 frame content", frame_bits, e);
        end
      end
      prev_valid = frame_valid;
    end
  end

  function automatic logic [CW-1:0] chunk_of(input logic [FW-1:0] img, input int k);
    logic [CW-1:0] c;
    int row, col0;
    row  = k / 2;
    col0 = (k % 2) * CW;
    for (int j = 0; j < CW; j++) c[j] = img[row*COLS + col0 + j];
    return c;
  endfunction

  // driver: sends chunks 0..last, pushes expected frame when complete
  task automatic send_frame(input logic [FW-1:0] img, input bit hold_low,
                            input int last, input bit timing);
    if (last == NCH - 1) exp_q.push_back(img);
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      in_bus = {(k == 0) ? 1'b0 : ~hold_low, chunk_of(img, k)};
    end
    if (timing && last == NCH - 1) begin
      @(negedge clk);
      check(frame_valid == 1'b1, "R4 valid one cycle after chunk 27",
            FW'(frame_valid), FW'(1));
    end
  endtask

  task automatic idle(input int n, input bit strobe_n, input logic [FW-1:0] held,
                      input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(frame_bits == held, req, frame_bits, held);
      in_bus = {strobe_n, CW'($urandom)};
    end
    @(negedge clk);
    check(frame_bits == held, req, frame_bits, held);
  endtask

  function automatic logic [FW-1:0] rand_img();
    logic [FW-1:0] v;
    for (int i = 0; i < FW; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [FW-1:0] shape, chk, ones, rimg, corner, held;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        shape[r*COLS+c] = (c == 2) || (r == 11 && c < 9) || (r == 0 && c == 13);
        chk[r*COLS+c]   = ((r + c) % 2) == 0;
      end
    ones   = '1;
    corner = '0;
    corner[0] = 1'b1;
    corner[FW-1] = 1'b1;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(frame_bits == '0, "R1 frame cleared by reset", frame_bits, '0);
    check(frame_valid == 1'b0, "R1 valid low after reset", FW'(frame_valid), '0);

    // R2/R3/R4 first picture
    send_frame(shape, 1'b0, NCH-1, 1'b1);
    // R5 idle with random pixels
    idle(15, 1'b1, shape, "R5 frame held while idle");

    // R9 back to back pictures
    send_frame(chk, 1'b0, NCH-1, 1'b0);
    send_frame(ones, 1'b0, NCH-1, 1'b0);
    rimg = rand_img();
    send_frame(rimg, 1'b0, NCH-1, 1'b1);
    idle(3, 1'b1, rimg, "R9 last of back-to-back held");

    // R6 restart mid-picture
    send_frame(rand_img(), 1'b0, 10, 1'b0);
    send_frame(corner, 1'b0, NCH-1, 1'b1);
    idle(3, 1'b1, corner, "R6 restarted picture held");

    // R7 start clears everything but chunk 0
    @(negedge clk);
    in_bus = {1'b0, 7'h55};
    @(negedge clk);
    check(frame_bits == FW'(7'h55), "R7 buffer after start", frame_bits, FW'(7'h55));
    in_bus = {1'b1, 7'h0F};
    @(negedge clk);
    check(frame_bits == FW'({7'h0F, 7'h55}), "R3 chunk 1 at bits 13..7",
          frame_bits, FW'({7'h0F, 7'h55}));
    // abandon it with a restart (R6)
    rimg = rand_img();
    send_frame(rimg, 1'b0, NCH-1, 1'b1);

    // R8 strobe held low through a picture and afterwards
    held = rand_img();
    send_frame(held, 1'b1, NCH-1, 1'b1);
    idle(10, 1'b0, held, "R8 held-low strobe ignored after picture");
    idle(4, 1'b1, held, "R5 frame held after strobe released");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 every picture produced one valid",
          FW'(exp_q.size()), '0);
    finish_run();
  end
endmodule